// File: doc/BRIEF.md
# Cycle-Stealing Block Transfer Controller

This controller moves a block of words between one peripheral and memory so that the processor does not handle each word itself. The processor first programs a start address, a word count, a direction and a peripheral identifier through a small register port. It then starts the job by writing a go bit. From then on the controller works through the block one word at a time. It waits for the peripheral to ask for service and requests the shared bus. When the grant arrives, it moves a single word directly between the peripheral and memory in one bus cycle. It then drops its request, so the processor gets the bus back before the next word.

The block is built around one state machine with four states:

- `ST_IDLE`: no job is running.
- `ST_WAIT_DREQ`: a job is running and the controller waits for the peripheral's request, with the bus released.
- `ST_REQ_BUS`: the bus request is raised and the controller waits for the grant.
- `ST_XFER`: the single transfer cycle.

The transitions are:

- `ST_IDLE` to `ST_WAIT_DREQ` on a go write with a non-zero count.
- `ST_IDLE` stays in `ST_IDLE` on a go write with a zero count, and the job is reported complete at once.
- `ST_WAIT_DREQ` to `ST_REQ_BUS` when the peripheral request is seen.
- `ST_REQ_BUS` to `ST_XFER` when the grant is seen.
- `ST_XFER` to `ST_WAIT_DREQ` after a word that was not the last.
- `ST_XFER` to `ST_IDLE` after the last word.
- `ST_XFER` back to `ST_REQ_BUS` if the grant is withdrawn before the word moves.

When the last word has moved, the controller sets a done flag and raises its interrupt line. A write to the status register clears both.

Top module: `cs_dma_ctrl`

## Requirements
- R1: Register port. `reg_sel` selects the register: 0 is the memory address, 1 is the remaining word count, 2 is control and 3 is status. Reads return the register's current value through a combinational path. Control bit 0 is go and reads back as 0. Control bit 1 is the direction: 0 means peripheral to memory and 1 means memory to peripheral. Control bits 7:4 hold the peripheral identifier. In the status register, bit 0 is busy and bit 1 is done.
- R2: While a job is running, `bus_req` rises only after `dev_dreq` has been sampled high. While `dev_dreq` stays low, `bus_req` stays low and busy stays set.
- R3: Memory strobes (`mem_we`, `mem_re`) are asserted only while `bus_gnt` is high. Each word is acknowledged by exactly one `dev_ack` pulse that lasts one cycle.
- R4: In the cycle after each word, `bus_req` is low, so the bus returns to the processor between words.
- R5: With direction 0, each word on `dev_rdata` is written to memory at the current address in the single cycle that carries `dev_ack`.
- R6: With direction 1, memory is read at the current address, and `mem_rdata` is presented on `dev_wdata` in the `dev_ack` cycle.
- R7: After each word the address rises by one and the count falls by one. At the end of the job the address register reads start plus length and the count register reads 0.
- R8: After the last word, done and `irq` are set and busy is clear.
- R9: Any write to the status register clears done and `irq`.
- R10: A go write with a count of zero sets done and `irq` at once and never raises `bus_req`.
- R11: While busy, writes to the address, count and control registers have no effect.
- R12: After reset, busy, done, `irq` and `bus_req` are 0.
- R13: During every `dev_ack`, `dev_sel` carries the programmed peripheral identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| bus_req | output | 1 | Shared bus request |
| bus_gnt | input | 1 | Shared bus grant |
| mem_addr | output | ADDR_W | Memory address, driven only during a granted word |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | DATA_W | Data written to memory |
| mem_rdata | input | DATA_W | Data read from memory |
| dev_dreq | input | 1 | Peripheral service request |
| dev_ack | output | 1 | One-cycle peripheral acknowledge per word |
| dev_sel | output | DEV_W | Peripheral identifier |
| dev_rdata | input | DATA_W | Word supplied by the peripheral |
| dev_wdata | output | DATA_W | Word delivered to the peripheral |
| irq | output | 1 | Completion interrupt |

## Verification
Random jobs vary the length, start address, direction and identifier. Meanwhile the peripheral request and the bus grant toggle at random, so grants that arrive late or are withdrawn are kept apart from real word transfers. Comparing memory against the peripheral buffer shows whether both directions are correct and whether the address advances one step per word. Directed cases cover a zero-length go, a one-word job, and writes that land while a job is held off by a missing request; these separate the immediate-completion path and the write-blocking rule from normal progress. A per-cycle monitor watches that the bus is released after every word, that strobes appear only under grant, and that the identifier is correct at each acknowledge.

// File: rtl/dma_pkg.sv
package dma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_DREQ,
        ST_REQ_BUS,
        ST_XFER
    } dma_state_e;

    localparam logic [1:0] REG_ADDR  = 2'd0;
    localparam logic [1:0] REG_COUNT = 2'd1;
    localparam logic [1:0] REG_CTRL  = 2'd2;
    localparam logic [1:0] REG_STAT  = 2'd3;

    localparam int CTRL_GO      = 0;
    localparam int CTRL_DIR     = 1;
    localparam int CTRL_DEV_LSB = 4;
    localparam int STAT_BUSY    = 0;
    localparam int STAT_DONE    = 1;
endpackage

// File: rtl/dma_regfile.sv
module dma_regfile
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DEV_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              busy,
    input  logic              step,
    input  logic              finish,
    output logic [ADDR_W-1:0] addr_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              dir_q,
    output logic [DEV_W-1:0]  dev_q,
    output logic              done_q,
    output logic              go,
    output logic              last,
    output logic              cnt_zero,
    output logic [DATA_W-1:0] reg_rdata
);
    logic              wr_open;
    logic [ADDR_W-1:0] span;

    assign wr_open  = reg_wr && !busy;
    assign go       = wr_open && (reg_sel == REG_CTRL) && reg_wdata[CTRL_GO];
    assign cnt_zero = (cnt_q == '0);
    assign last     = (cnt_q == CNT_W'(1));
    assign span     = addr_q + ADDR_W'(cnt_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (step) begin
            addr_q <= addr_q + ADDR_W'(1);
        end else if (wr_open && reg_sel == REG_ADDR) begin
            addr_q <= reg_wdata[ADDR_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end else if (wr_open && reg_sel == REG_COUNT) begin
            cnt_q <= reg_wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= 1'b0;
            dev_q <= '0;
        end else if (wr_open && reg_sel == REG_CTRL) begin
            dir_q <= reg_wdata[CTRL_DIR];
            dev_q <= reg_wdata[CTRL_DEV_LSB +: DEV_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (finish) begin
            done_q <= 1'b1;
        end else if (reg_wr && reg_sel == REG_STAT) begin
            done_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            REG_ADDR:  reg_rdata = DATA_W'(addr_q);
            REG_COUNT: reg_rdata = DATA_W'(cnt_q);
            REG_CTRL: begin
                reg_rdata[CTRL_DIR]               = dir_q;
                reg_rdata[CTRL_DEV_LSB +: DEV_W]  = dev_q;
            end
            REG_STAT: begin
                reg_rdata[STAT_BUSY] = busy;
                reg_rdata[STAT_DONE] = done_q;
            end
        endcase
    end

    // R7: address plus remaining count is invariant while a job runs
    assert_span_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (span == $past(span)));

    // R11: programming registers frozen while busy
    assert_ctrl_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(dir_q) && $stable(dev_q)));
endmodule

// File: rtl/dma_fsm.sv
module dma_fsm
    import dma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic cnt_zero,
    input  logic last,
    input  logic dreq,
    input  logic gnt,
    output logic busy,
    output logic bus_req,
    output logic step,
    output logic finish
);
    dma_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (go && !cnt_zero) state_d = ST_WAIT_DREQ;
            ST_WAIT_DREQ: if (dreq) state_d = ST_REQ_BUS;
            ST_REQ_BUS:   if (gnt) state_d = ST_XFER;
            ST_XFER: begin
                if (!gnt)      state_d = ST_REQ_BUS;
                else if (last) state_d = ST_IDLE;
                else           state_d = ST_WAIT_DREQ;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        busy    = (state_q != ST_IDLE);
        bus_req = (state_q == ST_REQ_BUS) || (state_q == ST_XFER);
        step    = (state_q == ST_XFER) && gnt;
        finish  = (go && cnt_zero && state_q == ST_IDLE) || (step && last);
    end

    // R10: zero-length go never leaves idle
    assert_zero_len_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (go && cnt_zero) |=> (state_q == ST_IDLE));

    // R2: bus request rises only after a sampled peripheral request
    assert_req_after_dreq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(dreq));
endmodule

// File: rtl/dma_datapath.sv
module dma_datapath #(
    parameter int ADDR_W = 16,
    parameter int DEV_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              step,
    input  logic              dir,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DEV_W-1:0]  dev_q,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] dev_wdata,
    output logic [DEV_W-1:0]  dev_sel
);
    always_comb begin
        mem_addr  = step ? addr_q : '0;
        mem_we    = step && !dir;
        mem_re    = step && dir;
        mem_wdata = (step && !dir) ? dev_rdata : '0;
        dev_wdata = (step && dir) ? mem_rdata : '0;
        dev_sel   = dev_q;
    end
endmodule

// File: rtl/cs_dma_ctrl.sv
module cs_dma_ctrl
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DEV_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              dev_dreq,
    output logic              dev_ack,
    output logic [DEV_W-1:0]  dev_sel,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic [DATA_W-1:0] dev_wdata,
    output logic              irq
);
    logic              busy, step, finish, go, last, cnt_zero, dir_q, done_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DEV_W-1:0]  dev_q;

    dma_regfile #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEV_W(DEV_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .busy(busy), .step(step), .finish(finish),
        .addr_q(addr_q), .cnt_q(cnt_q), .dir_q(dir_q), .dev_q(dev_q),
        .done_q(done_q), .go(go), .last(last), .cnt_zero(cnt_zero),
        .reg_rdata(reg_rdata)
    );

    dma_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .go(go), .cnt_zero(cnt_zero), .last(last),
        .dreq(dev_dreq), .gnt(bus_gnt), .busy(busy), .bus_req(bus_req),
        .step(step), .finish(finish)
    );

    dma_datapath #(.ADDR_W(ADDR_W), .DEV_W(DEV_W), .DATA_W(DATA_W)) u_path (
        .step(step), .dir(dir_q), .addr_q(addr_q), .dev_q(dev_q),
        .mem_rdata(mem_rdata), .dev_rdata(dev_rdata), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
        .dev_wdata(dev_wdata), .dev_sel(dev_sel)
    );

    assign dev_ack = step;
    assign irq     = done_q;

    // R3: memory strobes only under grant
    assert_strobe_granted_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> bus_gnt);

    // R3: acknowledge lasts a single cycle
    assert_ack_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ack |=> !dev_ack);

    // R4: bus handed back after every word
    assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ack |=> !bus_req);

    // R8: interrupt appears only once the job has ended
    assert_irq_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> !bus_req);
endmodule

// File: tb/tb_cs_dma_ctrl.sv
module tb_cs_dma_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_sel = 2'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          bus_req, bus_gnt = 1'b0;
    logic [15:0]   mem_addr;
    logic          mem_we, mem_re;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic          dev_dreq = 1'b0, dev_ack;
    logic [3:0]    dev_sel;
    logic [DW-1:0] dev_rdata, dev_wdata;
    logic          irq;

    cs_dma_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dev_dreq(dev_dreq),
        .dev_ack(dev_ack), .dev_sel(dev_sel), .dev_rdata(dev_rdata),
        .dev_wdata(dev_wdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_bad = 0, cycles = 0;
    logic [DW-1:0] mem [256];
    logic [DW-1:0] dbuf [16];
    int  didx = 0, acks = 0, tnum = 0;
    bit  dev_en = 0, gnt_en = 1, req_seen = 0, ack_prev = 0;
    bit  cur_dir = 0;
    logic [3:0] cur_dev = '0;

    function automatic logic [DW-1:0] mem_init(int k);
        return DW'(k * 37 + 5);
    endfunction

    function automatic logic [DW-1:0] dev_word(int t, int i);
        return DW'(t * 1000 + i * 7 + 3);
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    assign mem_rdata = mem[mem_addr[7:0]];
    assign dev_rdata = dev_word(tnum, didx);

    // memory and peripheral models
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        if (dev_ack) begin
            if (cur_dir) dbuf[didx[3:0]] <= dev_wdata;
            didx <= didx + 1;
            acks <= acks + 1;
        end
    end

    // random request and grant, changed just after the edge
    always @(posedge clk) begin
        #1;
        dev_dreq = dev_en && ($urandom % 4 != 0);
        bus_gnt  = gnt_en && bus_req && ($urandom % 3 != 0);
    end

    // cycle monitor, mid-cycle
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (bus_req) req_seen = 1;
            if (mem_we || mem_re) chk(bus_gnt, "R3 strobe without grant", bus_gnt, 1);
            if (ack_prev) chk(!bus_req && !dev_ack, "R4 bus not released", bus_req, 0);
            if (dev_ack) chk(dev_sel == cur_dev, "R13 dev_sel", dev_sel, cur_dev);
            ack_prev = dev_ack;
        end
        if (cycles > 150000) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic wr(logic [1:0] sel, logic [DW-1:0] d);
        @(negedge clk);
        reg_wr = 1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(logic [1:0] sel, output logic [DW-1:0] v);
        @(negedge clk);
        reg_sel = sel;
        #1 v = reg_rdata;
    endtask

    task automatic wait_done(output bit ok);
        logic [DW-1:0] s;
        ok = 0;
        for (int i = 0; i < 3000; i++) begin
            rd(2'd3, s);
            if (s[1]) begin ok = 1; break; end
        end
    endtask

    task automatic run_job(int t, bit dir, int addr, int n, logic [3:0] dev, bit hold_writes);
        logic [DW-1:0] v;
        logic [DW-1:0] snap [16];
        bit ok;
        for (int i = 0; i < n; i++) snap[i] = mem[(addr + i) % 256];
        tnum = t; didx = 0; acks = 0; cur_dir = dir; cur_dev = dev;
        wr(2'd0, DW'(addr));
        wr(2'd1, DW'(n));
        wr(2'd2, DW'({dev, 2'b00, dir, 1'b1}));
        if (hold_writes) begin
            repeat (8) @(negedge clk);
            chk(!bus_req, "R2 request without dreq", bus_req, 0);
            rd(2'd3, v);
            chk(v[0] == 1'b1, "R2 busy while waiting", v[0], 1);
            wr(2'd0, 16'h00EE);
            wr(2'd1, 16'd3);
            wr(2'd2, DW'({4'hF, 2'b00, ~dir, 1'b1}));
            rd(2'd0, v);
            chk(v == DW'(addr), "R11 address write ignored", v, addr);
            rd(2'd1, v);
            chk(v == DW'(n), "R11 count write ignored", v, n);
            rd(2'd2, v);
            chk(v == DW'({dev, 2'b00, dir, 1'b0}), "R1 R11 control readback", v,
                {dev, 2'b00, dir, 1'b0});
        end
        dev_en = 1;
        wait_done(ok);
        dev_en = 0;
        chk(ok, "R8 job completes", ok, 1);
        rd(2'd3, v);
        chk(v[1:0] == 2'b10 && irq, "R8 done, irq, not busy", {irq, v[1:0]}, 3'b110);
        rd(2'd0, v);
        chk(v == DW'(addr + n), "R7 final address", v, addr + n);
        rd(2'd1, v);
        chk(v == 0, "R7 final count", v, 0);
        chk(acks == n, "R3 one ack per word", acks, n);
        for (int i = 0; i < n; i++) begin
            if (!dir)
                chk(mem[(addr + i) % 256] == dev_word(t, i), "R5 word in memory",
                    mem[(addr + i) % 256], dev_word(t, i));
            else
                chk(dbuf[i] == snap[i], "R6 word at peripheral", dbuf[i], snap[i]);
        end
        wr(2'd3, '0);
        rd(2'd3, v);
        chk(v[1] == 0 && !irq, "R9 status write clears", {irq, v[1]}, 0);
    endtask

    initial begin
        logic [DW-1:0] v;
        void'($urandom(32'd20251));
        for (int k = 0; k < 256; k++) mem[k] = mem_init(k);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        rd(2'd3, v);
        chk(v[1:0] == 0 && !irq && !bus_req, "R12 reset state", {bus_req, irq, v[1:0]}, 0);

        // R10 zero length
        req_seen = 0;
        wr(2'd1, 16'd0);
        wr(2'd2, 16'h0031);
        rd(2'd3, v);
        chk(v[1:0] == 2'b10 && irq, "R10 zero count done", {irq, v[1:0]}, 3'b110);
        repeat (5) @(negedge clk);
        chk(!req_seen, "R10 no bus request", req_seen, 0);
        wr(2'd3, '0);

        // directed: one word each way, then held job with blocked writes
        run_job(1, 0, 10, 1, 4'h2, 0);
        run_job(2, 1, 10, 1, 4'h5, 0);
        run_job(3, 0, 40, 6, 4'h9, 1);
        // wrap of grant withdrawal covered by random gnt; random jobs
        for (int j = 0; j < 12; j++) begin
            run_job(10 + j, 1'($urandom % 2), int'($urandom % 200),
                    1 + int'($urandom % 12), 4'($urandom), 0);
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule